// File: doc/BRIEF.md
# I2C Port Expander

This block is an I2C slave that gives a bus master control of one bidirectional parallel port through four byte-wide registers. Those registers are output latch, input view, polarity mask and direction. The 7-bit device address is split in two. The high bits are a build-time constant and the low bits come from strap pins, so several identical expanders can share one bus.

A write transfer carries a command byte, then any number of data bytes. The low two bits of the command byte choose the register that the data bytes, and any later reads, refer to. A read transfer returns the chosen register again and again until the master declines a byte. The command is kept across STOP and repeated START, so a master can set it once and then poll with short read transfers.

The port itself is a plain register-driven interface. Per-bit output enables come from the direction register. The output values come from the output latch, gated to zero on pins set as inputs. The pin levels pass through a two-flop synchronizer before they reach the input view. SCL and SDA are oversampled on the system clock after synchronization. The device only ever pulls SDA low and never stretches SCL.

Top module: `i2c_port_expander`

## Requirements
- R1: The device address is `{ADDR_BASE[6:ADDR_PINS], addr_pins}` (default 7'h18 with pins 3'b101 gives 7'h1D). Only that address is acknowledged, with SDA low during the ninth clock. Any other address gets no acknowledge, and no register changes during that transfer.
- R2: The bit after the address selects the direction: 0 is a write (command and data bytes follow from the master) and 1 is a read (the slave sends bytes MSB first and the master acknowledges each one).
- R3: In a write, the first byte after the address is the command. Its bits [1:0] select the register (0 input view, 1 output latch, 2 polarity mask, 3 direction) and bits [7:2] are ignored. Each data byte changes at most the selected register, and registers change only on data bytes.
- R4: Reading register 0 returns the synchronized level of every pin XOR the polarity mask, for input and output pins alike.
- R5: Reading register 1 returns the output latch, not the pin levels.
- R6: A direction bit of 0 makes the pin an output: `pin_oe` is 1 and `pin_out` equals the latch bit. A direction bit of 1 makes it an input: `pin_oe` is 0 and `pin_out` is 0.
- R7: After reset the direction register is 0xFF, the output latch 0x00 and the polarity mask 0x00, so `pin_oe` and `pin_out` are all zero.
- R8: Data bytes written while register 0 is selected are acknowledged but change no register.
- R9: Consecutive data bytes in one write all go to the selected register, and the last one wins. Consecutive read bytes each return the selected register.
- R10: A read uses the register chosen by the most recent command byte, whether the read follows a repeated START or a STOP and a new START.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START.
- R12: START and STOP are SDA falling and rising edges while SCL is high. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_pins | input | ADDR_PINS (3) | Strap pins for the low address bits |
| pin_in | input | PORT_W (8) | Sensed levels of the port pins |
| pin_out | output | PORT_W (8) | Drive value per pin, zero on input pins |
| pin_oe | output | PORT_W (8) | Output enable per pin |

## Verification
A fault in the register file shows up at `pin_oe` and `pin_out` as soon as the data byte's acknowledge clock starts. A fault in the command latch or the read multiplexer appears in the first bit shifted out by the next read transfer. A fault in the bit-level state machine shows up within one byte, either as a missing or extra acknowledge or as a shifted read value, because every transfer in the bench checks every acknowledge bit. A wrong read-back after a bad address, a write to the input view, or a STOP between command and read exposes state that should have been left untouched.

// File: rtl/pex_pkg.sv
package pex_pkg;

   // Register selected by bits [1:0] of the command byte
   typedef enum logic [1:0] {
      SEL_IN  = 2'd0,
      SEL_OUT = 2'd1,
      SEL_POL = 2'd2,
      SEL_DIR = 2'd3
   } reg_sel_e;

   // Bit-level states of the bus engine
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } bus_st_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("pex_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("pex_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {(STAGES*W){RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pex_link.sv
module pex_link
   import pex_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl,
   input  logic              sda,
   input  logic [6:0]        dev_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output reg_sel_e          sel,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data
);

   logic              scl_d, sda_d;
   logic              scl_rise, scl_fall, start_c, stop_c;
   bus_st_e           state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-2:0] tx_sh;
   logic              rw_q, nack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl;
         sda_d <= sda;
      end
   end

   assign scl_rise = scl & ~scl_d;
   assign scl_fall = ~scl & scl_d;
   assign start_c  = scl & scl_d & sda_d & ~sda;
   assign stop_c   = scl & scl_d & ~sda_d & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         rw_q    <= 1'b0;
         nack_q  <= 1'b0;
         sda_oe  <= 1'b0;
         sel     <= SEL_IN;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (state == ST_ADDR) begin
                        if (rx_sh[7:1] == dev_addr) begin
                           rw_q   <= rx_sh[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_CMD) begin
                        sel    <= reg_sel_e'(rx_sh[1:0]);
                        sda_oe <= 1'b1;
                        state  <= ST_CMD_ACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_data <= rx_sh;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR_ACK && rw_q) begin
                        tx_sh  <= rd_data[BYTE_W-2:0];
                        sda_oe <= ~rd_data[BYTE_W-1];
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= (state == ST_ADDR_ACK) ? ST_CMD : ST_WDATA;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~tx_sh[BYTE_W-2];
                        tx_sh  <= {tx_sh[BYTE_W-3:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     nack_q <= sda;
                  end else if (scl_fall) begin
                     if (nack_q) begin
                        state <= ST_IDLE;
                     end else begin
                        bit_cnt <= '0;
                        tx_sh   <= rd_data[BYTE_W-2:0];
                        sda_oe  <= ~rd_data[BYTE_W-1];
                        state   <= ST_RDATA;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R12: drive changes happen only in the SCL low phase
   a_r12_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl));

   // R11: an idle engine never holds the data line
   a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R1: an acknowledge after the address byte only follows an address match
   a_r1_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> ($past(rx_sh[7:1]) == dev_addr));

endmodule

// File: rtl/pex_regs.sv
module pex_regs
   import pex_pkg::*;
#(
   parameter int          W       = 8,
   parameter logic [7:0]  RST_OUT = 8'h00,
   parameter logic [7:0]  RST_POL = 8'h00,
   parameter logic [7:0]  RST_DIR = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_sel_e          sel,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [W-1:0]      pin_lvl,
   output logic [BYTE_W-1:0] rd_data,
   output logic [W-1:0]      pin_out,
   output logic [W-1:0]      pin_oe
);

   if (W < 1 || W > BYTE_W) begin : g_bad_width
      $error("pex_regs: W must be 1 to 8");
   end

   logic [W-1:0] out_q, pol_q, dir_q, in_view, rd_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= RST_OUT[W-1:0];
         pol_q <= RST_POL[W-1:0];
         dir_q <= RST_DIR[W-1:0];
      end else if (wr_en) begin
         case (sel)
            SEL_OUT: out_q <= wr_data[W-1:0];
            SEL_POL: pol_q <= wr_data[W-1:0];
            SEL_DIR: dir_q <= wr_data[W-1:0];
            default: ;
         endcase
      end
   end

   // One slice per pin: input view, direction and drive gating
   for (genvar i = 0; i < W; i++) begin : g_pin
      assign in_view[i] = pin_lvl[i] ^ pol_q[i];
      assign pin_oe[i]  = ~dir_q[i];
      assign pin_out[i] = dir_q[i] ? 1'b0 : out_q[i];
   end

   always_comb begin
      case (sel)
         SEL_IN:  rd_w = in_view;
         SEL_OUT: rd_w = out_q;
         SEL_POL: rd_w = pol_q;
         default: rd_w = dir_q;
      endcase
   end

   if (W == BYTE_W) begin : g_full
      assign rd_data = rd_w;
   end else begin : g_pad
      assign rd_data = {{(BYTE_W-W){1'b0}}, rd_w};
   end

   // R8: a write aimed at the input view leaves every register alone
   a_r8_input_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

   // R3: one data byte touches at most one register
   a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ($countones({out_q != $past(out_q), pol_q != $past(pol_q),
                             dir_q != $past(dir_q)}) <= 1));

   // R3: registers move only on a data byte
   a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
   import pex_pkg::*;
#(
   parameter int         PORT_W      = 8,
   parameter int         ADDR_PINS   = 3,
   parameter logic [6:0] ADDR_BASE   = 7'h18,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   input  logic [ADDR_PINS-1:0] addr_pins,
   input  logic [PORT_W-1:0]    pin_in,
   output logic [PORT_W-1:0]    pin_out,
   output logic [PORT_W-1:0]    pin_oe
);

   if (PORT_W < 1 || PORT_W > BYTE_W) begin : g_bad_port
      $error("i2c_port_expander: PORT_W must be 1 to 8");
   end
   if (ADDR_PINS < 1 || ADDR_PINS > 6) begin : g_bad_pins
      $error("i2c_port_expander: ADDR_PINS must be 1 to 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_port_expander: SYNC_STAGES must be at least 2");
   end

   localparam int FIX_W = 7 - ADDR_PINS;

   logic [1:0]        bus_s;
   logic [PORT_W-1:0] pin_s;
   logic [6:0]        dev_addr;
   reg_sel_e          sel;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_data, rd_data;

   assign dev_addr = {ADDR_BASE[6 -: FIX_W], addr_pins};

   pex_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   pex_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   pex_link u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (bus_s[1]),
      .sda      (bus_s[0]),
      .dev_addr (dev_addr),
      .rd_data  (rd_data),
      .sda_oe   (sda_oe),
      .sel      (sel),
      .wr_en    (wr_en),
      .wr_data  (wr_data)
   );

   pex_regs #(.W(PORT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pin_lvl (pin_s),
      .rd_data (rd_data),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   // R6: an input pin never carries a drive value
   a_r6_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/sim_i2c_port_expander.sv
module sim_i2c_port_expander;

   localparam int CLK_PERIOD = 10;
   localparam int T          = 10;
   localparam int WD_CYCLES  = 150000;
   localparam logic [6:0] DEV = 7'h1D;

   // {cmd, write data, pin levels, expected read}
   localparam logic [31:0] VEC [7] = '{
      {8'h01, 8'hA5, 8'h00, 8'hA5},
      {8'h02, 8'h0F, 8'h3C, 8'h0F},
      {8'h03, 8'hF0, 8'h00, 8'hF0},
      {8'h00, 8'hFF, 8'h3C, 8'h33},
      {8'h05, 8'h5A, 8'hFF, 8'h5A},
      {8'h0E, 8'h00, 8'h96, 8'h00},
      {8'h00, 8'h12, 8'h96, 8'h96}
   };
   localparam string VREQ [7] = '{"R5", "R3", "R6", "R4", "R3", "R3", "R4"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic sda_oe, sda_bus;
   logic [2:0] addr_pins = 3'b101;
   logic [7:0] pin_in = 8'h00, pin_out, pin_oe;
   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus = m_sda & ~sda_oe;

   i2c_port_expander u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .addr_pins (addr_pins),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      m_sda = 1'b1; tick(T);
      m_scl = 1'b1; tick(T);
      m_sda = 1'b0; tick(T);
      m_scl = 1'b0;
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; tick(T);
      m_scl = 1'b1; tick(T);
      m_sda = 1'b1; tick(T);
   endtask

   task automatic clock_bit(output logic v);
      tick(T);
      m_scl = 1'b1; tick(T);
      v = sda_bus;  tick(T);
      m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic v;
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i];
         clock_bit(v);
      end
      m_sda = 1'b1;
      clock_bit(v);
      ack = ~v;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic v;
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         clock_bit(v);
         b = {b[6:0], v};
      end
      m_sda = ~give_ack;
      clock_bit(v);
      m_sda = 1'b1;
   endtask

   task automatic reg_write(input logic [7:0] cmd, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2, input int n);
      logic ack;
      logic [7:0] d [3];
      d = '{d0, d1, d2};
      bus_start;
      send_byte({DEV, 1'b0}, ack); chk("R1 write address ack", {7'd0, ack}, 8'd1);
      send_byte(cmd, ack);         chk("R2 command ack", {7'd0, ack}, 8'd1);
      for (int k = 0; k < n; k++) begin
         send_byte(d[k], ack);     chk("R2 data ack", {7'd0, ack}, 8'd1);
      end
      bus_stop;
   endtask

   // Reads nbytes (1 or 2) after setting the command; b1 is the last byte
   task automatic reg_read(input logic [7:0] cmd, input logic via_stop, input int nbytes,
                           output logic [7:0] b0, output logic [7:0] b1);
      logic ack;
      bus_start;
      send_byte({DEV, 1'b0}, ack); chk("R1 address ack", {7'd0, ack}, 8'd1);
      send_byte(cmd, ack);         chk("R2 command ack", {7'd0, ack}, 8'd1);
      if (via_stop) bus_stop;
      bus_start;
      send_byte({DEV, 1'b1}, ack); chk("R2 read address ack", {7'd0, ack}, 8'd1);
      recv_byte(nbytes > 1, b0);
      b1 = b0;
      if (nbytes > 1) recv_byte(1'b0, b1);
      bus_stop;
   endtask

   task automatic read_only(output logic [7:0] b);
      logic ack;
      bus_start;
      send_byte({DEV, 1'b1}, ack); chk("R10 read address ack", {7'd0, ack}, 8'd1);
      recv_byte(1'b0, b);
      bus_stop;
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] b0, b1;
      logic ack, v;
      tick(4);
      // R7: reset state at the pins
      chk("R7 pin_oe in reset", pin_oe, 8'h00);
      chk("R7 sda_oe in reset", {7'd0, sda_oe}, 8'h00);
      rst_n = 1'b1;
      tick(4);
      chk("R7 pin_out after reset", pin_out, 8'h00);
      reg_read(8'h03, 1'b0, 1, b0, b1); chk("R7 direction default", b0, 8'hFF);
      reg_read(8'h02, 1'b0, 1, b0, b1); chk("R7 polarity default", b0, 8'h00);
      reg_read(8'h01, 1'b0, 1, b0, b1); chk("R7 output default", b0, 8'h00);

      // Table: write one register, set pins, read back after repeated START
      for (int k = 0; k < 7; k++) begin
         reg_write(VEC[k][31:24], VEC[k][23:16], 8'h00, 8'h00, 1);
         pin_in = VEC[k][15:8];
         tick(5);
         reg_read(VEC[k][31:24], 1'b0, 1, b0, b1);
         chk(VREQ[k], b0, VEC[k][7:0]);
      end
      // State now: out 5A, pol 00, dir F0
      chk("R6 pin_oe follows direction", pin_oe, 8'h0F);
      chk("R6 pin_out gated by direction", pin_out, 8'h0A);

      // R8: write to input view changes nothing
      reg_write(8'h00, 8'h77, 8'h00, 8'h00, 1);
      reg_read(8'h01, 1'b0, 1, b0, b1); chk("R8 output unchanged", b0, 8'h5A);
      reg_read(8'h02, 1'b0, 1, b0, b1); chk("R8 polarity unchanged", b0, 8'h00);
      reg_read(8'h03, 1'b0, 1, b0, b1); chk("R8 direction unchanged", b0, 8'hF0);

      // R1: foreign address is not acknowledged and writes nothing
      bus_start;
      send_byte({7'h1C, 1'b0}, ack); chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
      send_byte(8'h01, ack);
      send_byte(8'hFF, ack);
      bus_stop;
      reg_read(8'h01, 1'b0, 1, b0, b1); chk("R1 foreign write ignored", b0, 8'h5A);

      // R9: burst write, last byte wins; burst read repeats the register
      reg_write(8'h01, 8'h11, 8'h22, 8'hC3, 3);
      chk("R9 pin_out after burst", pin_out, 8'h03);
      reg_read(8'h01, 1'b0, 2, b0, b1);
      chk("R9 first read byte", b0, 8'hC3);
      chk("R9 second read byte", b1, 8'hC3);

      // R10: command kept across STOP, read without a command byte
      reg_write(8'h03, 8'h00, 8'h00, 8'h00, 0);
      read_only(b0); chk("R10 read after stop", b0, 8'hF0);
      reg_read(8'h02, 1'b1, 1, b0, b1); chk("R10 stop between command and read", b0, 8'h00);

      // R11: after master NACK the slave lets go of SDA
      bus_start;
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h01, ack);
      bus_start;
      send_byte({DEV, 1'b1}, ack);
      recv_byte(1'b0, b0);  chk("R11 byte before nack", b0, 8'hC3);
      tick(T);
      chk("R11 released after nack", {7'd0, sda_oe}, 8'h00);
      clock_bit(v);
      chk("R11 line high on extra clock", {7'd0, v}, 8'h01);
      bus_stop;
      chk("R12 released after stop", {7'd0, sda_oe}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule